// File: doc/BRIEF.md
# Eight-Channel Output Protection Supervisor

This block decides, once per clock, whether each of eight high-side output channels may have its gate driven. Each channel has a command bit, an 8-bit junction temperature code in degrees Celsius and an overcurrent comparator flag. The channels share a supply-voltage code and a flag that reports whether the isolated input domain has settled. All of these inputs are synchronous digital values. The block produces one gate enable and one current-limit indication for each channel.

Each channel runs its own state machine with four states: `CH_RUN` (normal), `CH_PEAK` (an overcurrent has begun and the peak current is tolerated), `CH_LIMIT` (repetitive switched current limiting at the lower limit) and `CH_HOT` (thermal shutdown).

- `CH_RUN -> CH_PEAK`: the channel is driven and the overcurrent flag is high.
- `CH_PEAK -> CH_LIMIT`: the peak window of `PEAK_CYC` cycles has run out.
- `CH_PEAK` or `CH_LIMIT -> CH_RUN`: the overcurrent flag clears, or the channel stops being driven.
- Any state `-> CH_HOT`: the temperature is above the trip point. This transition has priority over all others.
- `CH_HOT -> CH_RUN`: the channel has cooled by the hysteresis. It restarts on its own, so a lasting fault produces a slow on/off cycle.

A shared supply monitor has two states. `SUP_LOCK` is the reset state. `SUP_LOCK -> SUP_RUN` happens when the supply code reaches the restart level. `SUP_RUN -> SUP_LOCK` happens when the supply code falls below the undervoltage trip level.

Top module: `prot_supervisor`

## Requirements
- R1: During reset and on the first cycle after it, every gate enable and every current-limit output is 0. The supply monitor starts in `SUP_LOCK`.
- R2: For a channel that is not tripped, with the supply in `SUP_RUN` and `ready_i` high, gate enable bit c equals `cmd_i[c]`.
- R3: The temperature of channel c is the unsigned code `temp_i[8c+7:8c]`. If it is above `T_TRIP` (default 135) at a rising edge, that channel's gate is 0 from that edge on. The gate stays 0 while the code remains above `T_TRIP - T_HYST` (default 125). A code of exactly 135 does not trip.
- R4: A thermally tripped channel restarts by itself at the first edge where its code is at or below `T_TRIP - T_HYST`. Its gate then follows its command again.
- R5: Thermal and overcurrent handling of one channel never changes the gate or current-limit output of another channel.
- R6: The supply code `vsup_i` is in units of 0.1 V. A code below `UV_TRIP` (default 100) locks all gates off. After a lock, the gates stay off until the code is at least `UV_RESTART` (default 105). While running, codes from `UV_TRIP` up to `UV_RESTART` keep the gates running.
- R7: While `ready_i` is low, all gates are 0.
- R8: Suppose a driven channel samples `oc_i[c]` high at edge E and keeps it high. Then `cur_lim_o[c]` is 0 up to and including edge E+`PEAK_CYC`-1 (default 4), and is 1 from edge E+`PEAK_CYC`. The gate stays on throughout.
- R9: At the first edge where `oc_i[c]` is sampled low, the channel returns to normal and `cur_lim_o[c]` becomes 0. This also applies during the peak window, which then never reaches current limit.
- R10: An overcurrent flag on a channel whose command is 0 has no effect: its `cur_lim_o` stays 0.
- R11: A thermal trip while in current limit takes priority. It clears both `cur_lim_o` and the gate of that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ready_i | input | 1 | Input-side domain is stable |
| vsup_i | input | 8 | Output supply code, 0.1 V per step |
| cmd_i | input | 8 | Per-channel on command |
| temp_i | input | 64 | Per-channel temperature codes in °C, channel c at bits 8c+7..8c |
| oc_i | input | 8 | Per-channel overcurrent comparator flags |
| gate_en_o | output | 8 | Per-channel final gate enable |
| cur_lim_o | output | 8 | Per-channel repetitive current-limit mode |

## Verification
Every state register here is observable at the ports within one edge. A channel that is stuck in `CH_HOT`, or that leaves it too early, shows a gate bit that disagrees with its command on the very next edge, when the bench crosses the hysteresis band. A wrong supply state turns all eight gates off together, or leaves them all on, on the edge after the supply code crosses a threshold. A peak counter that is off by even one cycle moves the rising edge of `cur_lim_o` away from edge E+`PEAK_CYC`.

// File: rtl/prot_pkg.sv
package prot_pkg;
    typedef enum logic [1:0] {
        CH_RUN   = 2'd0,
        CH_PEAK  = 2'd1,
        CH_LIMIT = 2'd2,
        CH_HOT   = 2'd3
    } ch_state_e;

    typedef enum logic {
        SUP_LOCK = 1'b0,
        SUP_RUN  = 1'b1
    } sup_state_e;
endpackage

// File: rtl/prot_supply_guard.sv
module prot_supply_guard
    import prot_pkg::*;
#(
    parameter int VW         = 8,
    parameter int UV_TRIP    = 100,
    parameter int UV_RESTART = 105
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] vsup_i,
    output logic          run_o
);
    localparam logic [VW-1:0] TRIP_C = VW'(UV_TRIP);
    localparam logic [VW-1:0] REST_C = VW'(UV_RESTART);

    sup_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SUP_LOCK;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SUP_LOCK: if (vsup_i >= REST_C) nxt = SUP_RUN;
            SUP_RUN:  if (vsup_i <  TRIP_C) nxt = SUP_LOCK;
            default:  nxt = SUP_LOCK;
        endcase
    end

    always_comb run_o = (state == SUP_RUN);

    p_uv_trip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vsup_i < TRIP_C) |=> !run_o);
    p_uv_hold_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_o && vsup_i < REST_C) |=> !run_o);
    p_uv_keep_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && vsup_i >= TRIP_C) |=> run_o);
endmodule

// File: rtl/prot_channel.sv
module prot_channel
    import prot_pkg::*;
#(
    parameter int TW        = 8,
    parameter int T_TRIP    = 135,
    parameter int T_RESTART = 125,
    parameter int PEAK_CYC  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          allow_i,
    input  logic          cmd_i,
    input  logic [TW-1:0] temp_i,
    input  logic          oc_i,
    output logic          gate_en_o,
    output logic          cur_lim_o
);
    localparam int CW = (PEAK_CYC < 2) ? 1 : $clog2(PEAK_CYC);
    localparam logic [TW-1:0] TRIP_C = TW'(T_TRIP);
    localparam logic [TW-1:0] RST_C  = TW'(T_RESTART);
    localparam logic [CW-1:0] LAST_C = CW'(PEAK_CYC - 1);

    ch_state_e     state, nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          drive;
    logic          hot_now;

    always_comb drive   = cmd_i && allow_i;
    always_comb hot_now = (temp_i > TRIP_C);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CH_RUN;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        if (hot_now) begin
            nxt = CH_HOT;
        end else begin
            unique case (state)
                CH_RUN: begin
                    if (drive && oc_i) begin
                        nxt     = CH_PEAK;
                        cnt_nxt = '0;
                    end
                end
                CH_PEAK: begin
                    if (!drive || !oc_i)  nxt = CH_RUN;
                    else if (cnt == LAST_C) nxt = CH_LIMIT;
                    else                  cnt_nxt = cnt + 1'b1;
                end
                CH_LIMIT: if (!drive || !oc_i) nxt = CH_RUN;
                CH_HOT:   if (temp_i <= RST_C) nxt = CH_RUN;
                default:  nxt = CH_RUN;
            endcase
        end
    end

    always_comb begin
        gate_en_o = drive && (state != CH_HOT);
        cur_lim_o = drive && (state == CH_LIMIT);
    end

    p_trip_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hot_now |=> !gate_en_o);
    p_hot_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_HOT && temp_i > RST_C) |=> !gate_en_o);
    p_auto_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_HOT && temp_i <= RST_C) |=> (state != CH_HOT));
    p_lim_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_LIMIT && !oc_i) |=> !cur_lim_o);
    p_idle_no_lim_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !drive |=> (state != CH_LIMIT));
    p_trip_clears_lim_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_LIMIT && hot_now) |=> (!cur_lim_o && !gate_en_o));
endmodule

// File: rtl/prot_supervisor.sv
module prot_supervisor
    import prot_pkg::*;
#(
    parameter int N_CH       = 8,
    parameter int TW         = 8,
    parameter int VW         = 8,
    parameter int T_TRIP     = 135,
    parameter int T_HYST     = 10,
    parameter int UV_TRIP    = 100,
    parameter int UV_RESTART = 105,
    parameter int PEAK_CYC   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ready_i,
    input  logic [VW-1:0]        vsup_i,
    input  logic [N_CH-1:0]      cmd_i,
    input  logic [N_CH*TW-1:0]   temp_i,
    input  logic [N_CH-1:0]      oc_i,
    output logic [N_CH-1:0]      gate_en_o,
    output logic [N_CH-1:0]      cur_lim_o
);
    localparam int T_RESTART = T_TRIP - T_HYST;

    logic sup_run;
    logic allow;

    prot_supply_guard #(
        .VW(VW), .UV_TRIP(UV_TRIP), .UV_RESTART(UV_RESTART)
    ) u_sup (
        .clk(clk), .rst_n(rst_n), .vsup_i(vsup_i), .run_o(sup_run)
    );

    always_comb allow = sup_run && ready_i;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        prot_channel #(
            .TW(TW), .T_TRIP(T_TRIP), .T_RESTART(T_RESTART), .PEAK_CYC(PEAK_CYC)
        ) u_ch (
            .clk(clk), .rst_n(rst_n), .allow_i(allow),
            .cmd_i(cmd_i[c]), .temp_i(temp_i[c*TW +: TW]), .oc_i(oc_i[c]),
            .gate_en_o(gate_en_o[c]), .cur_lim_o(cur_lim_o[c])
        );
    end

    p_not_ready_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |-> (gate_en_o == '0));
    p_lock_all_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_run |-> (gate_en_o == '0 && cur_lim_o == '0));
    p_gate_follows_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en_o & ~cmd_i) == '0);
endmodule

// File: tb/sim_prot_supervisor.sv
module sim_prot_supervisor;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ready_i;
    logic [7:0]  vsup_i;
    logic [7:0]  cmd_i;
    logic [63:0] temp_i;
    logic [7:0]  oc_i;
    logic [7:0]  gate_en_o;
    logic [7:0]  cur_lim_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    prot_supervisor u0 (
        .clk(clk), .rst_n(rst_n), .ready_i(ready_i), .vsup_i(vsup_i),
        .cmd_i(cmd_i), .temp_i(temp_i), .oc_i(oc_i),
        .gate_en_o(gate_en_o), .cur_lim_o(cur_lim_o)
    );

    // row: vsup | ready | cmd | hot mask (140 C, else 25 C) | expected gates
    localparam logic [39:0] VEC [11] = '{
        {8'd120, 8'd1, 8'hFF, 8'h00, 8'hFF},
        {8'd120, 8'd1, 8'hA5, 8'h00, 8'hA5},
        {8'd120, 8'd1, 8'hFF, 8'h11, 8'hEE},
        {8'd120, 8'd1, 8'hFF, 8'h00, 8'hFF},
        {8'd120, 8'd0, 8'hFF, 8'h00, 8'h00},
        {8'd95,  8'd1, 8'hFF, 8'h00, 8'h00},
        {8'd102, 8'd1, 8'hFF, 8'h00, 8'h00},
        {8'd110, 8'd1, 8'h3C, 8'h00, 8'h3C},
        {8'd102, 8'd1, 8'h3C, 8'h00, 8'h3C},
        {8'd120, 8'd1, 8'h0F, 8'hF0, 8'h0F},
        {8'd120, 8'd1, 8'h00, 8'h00, 8'h00}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic set_temp(input int ch, input int t);
        temp_i[ch*8 +: 8] = 8'(t);
    endtask

    task automatic all_cool();
        for (int c = 0; c < 8; c++) set_temp(c, 25);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ready_i = 1'b1; vsup_i = 8'd120; cmd_i = 8'hFF; oc_i = '0;
        all_cool();
        step(); step();
        chk("R1 gates in reset", gate_en_o, 8'h00);
        chk("R1 cur_lim in reset", cur_lim_o, 8'h00);
        @(negedge clk); rst_n = 1'b1; #1;
        chk("R1 locked before first edge", gate_en_o, 8'h00);

        // table walk: R2 R5 R6 R7
        for (int i = 0; i < 11; i++) begin
            vsup_i  = VEC[i][39:32];
            ready_i = VEC[i][24];
            cmd_i   = VEC[i][23:16];
            for (int c = 0; c < 8; c++) set_temp(c, VEC[i][8+c] ? 140 : 25);
            step();
            chk($sformatf("R2 R5 R6 R7 row %0d", i), gate_en_o, VEC[i][7:0]);
        end

        // thermal hysteresis on channel 2 (R3 R4)
        vsup_i = 8'd120; ready_i = 1'b1; cmd_i = 8'hFF; all_cool();
        step();
        set_temp(2, 135); step();
        chk("R3 135 does not trip", gate_en_o, 8'hFF);
        set_temp(2, 136); step();
        chk("R3 136 trips", gate_en_o, 8'hFB);
        set_temp(2, 130); step();
        chk("R3 hold at 130", gate_en_o, 8'hFB);
        set_temp(2, 126); step();
        chk("R3 hold at 126", gate_en_o, 8'hFB);
        set_temp(2, 125); step();
        chk("R4 restart at 125", gate_en_o, 8'hFF);

        // peak then limit on channel 5 (R8 R5)
        oc_i = 8'h20;
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R8 peak window no limit", cur_lim_o, 8'h00);
        end
        step();
        chk("R8 limit after peak", cur_lim_o, 8'h20);
        chk("R8 gate kept during limit", gate_en_o, 8'hFF);
        oc_i = 8'h00; step();
        chk("R9 limit released", cur_lim_o, 8'h00);

        // overcurrent aborts inside the peak window (R9)
        oc_i = 8'h20; step(); step();
        oc_i = 8'h00;
        for (int k = 0; k < 5; k++) step();
        chk("R9 aborted peak no limit", cur_lim_o, 8'h00);

        // overcurrent on an undriven channel (R10)
        cmd_i = 8'hBF; oc_i = 8'h40;
        for (int k = 0; k < 6; k++) step();
        chk("R10 undriven oc ignored", cur_lim_o, 8'h00);
        chk("R10 gates unaffected", gate_en_o, 8'hBF);
        oc_i = 8'h00; cmd_i = 8'hFF; step();

        // thermal trip overrides limit (R11)
        oc_i = 8'h20;
        for (int k = 0; k < 5; k++) step();
        chk("R11 in limit before trip", cur_lim_o, 8'h20);
        set_temp(5, 140); step();
        chk("R11 trip clears limit", cur_lim_o, 8'h00);
        chk("R11 trip clears gate", gate_en_o, 8'hDF);
        oc_i = 8'h00; set_temp(5, 25); step();
        chk("R4 channel 5 restarted", gate_en_o, 8'hFF);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule